// File: doc/BRIEF.md
# Overlay Pixel Visibility Resolver

This block sits in the per-pixel output path of an on-screen overlay. For every pixel clock it receives the hit flags of two overlay windows, a 4-bit attribute index, a 9-bit palette color (three bits each of red, green and blue) and a blink flag. It decides whether the overlay pixel is shown in its palette color, forced to black, or made transparent so that the video underneath passes through. The decision and the output color are registered, so they follow the inputs by exactly one clock.

Alongside the pixel path the block runs the blink timer from the vertical-sync pulses. It counts rising edges of vsync and flips a visible/hidden phase once per programmed period. The period is the 5-bit blink value times eight fields. The block also converts a 3-bit line-length code into the number of active pixels per line, for use by the pixel counters upstream.

Top module: `osd_blink_resolver`

## Requirements
- R1: While `rst` is high, the block drives `pix_mode` to transparent (0), `pix_color` to 0, `blink_phase` to 1 (visible) and `line_pixels` to 512.
- R2: When `cfg_osd_en` is 0, every pixel is transparent (`pix_mode` = 0), whatever the window, color and attribute inputs are.
- R3: Window w (0 or 1) counts as hit only when `cfg_osd_en`, `cfg_win_en[w]` and `win_hit[w]` are all 1. A pixel that hits no enabled window is transparent.
- R4: With `cfg_transp_dis` = 0, a hit pixel whose `pal_color` is all zeros and whose `attr_idx` lies in 0 to 7 is transparent.
- R5: With `cfg_transp_dis` = 1, that same all-zero pixel with `attr_idx` in 0 to 7 is output as black (`pix_mode` = 2, `pix_color` = 0).
- R6: A hit, visible pixel whose `pal_color` is all zeros and whose `attr_idx` lies in 8 to 15 is shown (`pix_mode` = 1, `pix_color` = 0) whatever `cfg_transp_dis` is.
- R7: When `cfg_blink_val` = B is nonzero, `blink_phase` inverts on every (8·B)-th rising edge of `vsync` and on no other edge. Its internal field count restarts from zero after each inversion.
- R8: While `cfg_blink_val` is 0, `blink_phase` is forced to 1 and the field count is cleared, so blinking pixels stay visible.
- R9: A hit pixel with `blink_flag` = 1 is transparent while `blink_phase` is 0. While `blink_phase` is 1 it is resolved like any other pixel. The phase used is the one present in the same cycle as the pixel inputs.
- R10: `line_pixels` equals 512 + 64·`cfg_ppl_code` (512 for code 0, 960 for code 7), one clock after the code is applied.
- R11: `pix_mode` and `pix_color` reflect the inputs of the previous clock (mode encoding 0 transparent, 1 shown, 2 black). `pix_color` equals the input color when the mode is shown and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_osd_en | input | 1 | Global overlay enable |
| cfg_win_en | input | 2 | Per-window enable, bit w for window w |
| cfg_transp_dis | input | 1 | 1 turns low-slot black into solid black instead of transparent |
| cfg_blink_val | input | 5 | Blink period in units of eight fields; 0 disables blinking |
| cfg_ppl_code | input | 3 | Active line length code |
| vsync | input | 1 | Vertical sync; each rising edge counts one field |
| win_hit | input | 2 | Current pixel lies inside window w |
| attr_idx | input | 4 | Attribute (palette slot) index of the pixel |
| pal_color | input | 9 | Palette color, R[8:6] G[5:3] B[2:0] |
| blink_flag | input | 1 | Pixel belongs to blinking content |
| pix_mode | output | 2 | Pixel decision: 0 transparent, 1 shown, 2 black |
| pix_color | output | 9 | Output color |
| blink_phase | output | 1 | 1 while blinking content is visible |
| line_pixels | output | 10 | Active pixels per line |

## Verification
The bench drives all-zero colors often so that the border between palette slot 7 and slot 8 is exercised in both transparency settings. A design that compared the slot index with the wrong bound, or ignored the disable bit, would hand the video through where black belongs, or the reverse. It changes the blink value between 0, 1, 2, 3 and 31 while vsync keeps pulsing. An off-by-one period, a phase that does not snap visible when blinking is turned off, or a counter that is not cleared would put `blink_phase` out of step with the model. Segments with one window enabled and the global enable dropped catch gating that ignores either enable. The one-cycle pairing of blink phase and pixel would expose a design that used the phase after the update.

// File: rtl/osd_res_pkg.sv
package osd_res_pkg;
  typedef enum logic [1:0] {
    PIX_TRANSP = 2'd0,
    PIX_SHOW   = 2'd1,
    PIX_BLACK  = 2'd2
  } pix_mode_e;
endpackage

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
  parameter int BLINK_W   = 5,
  parameter int MULT_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vsync,
  input  logic [BLINK_W-1:0] blink_val,
  output logic               phase_on
);
  localparam int CNT_W = BLINK_W + MULT_LOG2;

  logic             vs_q;
  logic [CNT_W-1:0] field_cnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W:0]   cnt_inc;
  logic             vs_edge;
  logic             period_done;

  assign period      = {blink_val, {MULT_LOG2{1'b0}}};
  assign vs_edge     = vsync & ~vs_q;
  assign cnt_inc     = {1'b0, field_cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign period_done = cnt_inc >= {1'b0, period};

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q      <= 1'b0;
      field_cnt <= '0;
      phase_on  <= 1'b1;
    end else begin
      vs_q <= vsync;
      if (blink_val == '0) begin
        field_cnt <= '0;
        phase_on  <= 1'b1;
      end else if (vs_edge) begin
        if (period_done) begin
          field_cnt <= '0;
          phase_on  <= ~phase_on;
        end else begin
          field_cnt <= cnt_inc[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/osd_pixel_resolve.sv
module osd_pixel_resolve
  import osd_res_pkg::*;
#(
  parameter int COLOR_W      = 9,
  parameter int ATTR_W       = 4,
  parameter int NUM_WIN      = 2,
  parameter int TRANSP_SLOTS = 8
) (
  input  logic               osd_en,
  input  logic [NUM_WIN-1:0] win_en,
  input  logic               transp_dis,
  input  logic               phase_on,
  input  logic [NUM_WIN-1:0] win_hit,
  input  logic [ATTR_W-1:0]  attr_idx,
  input  logic [COLOR_W-1:0] pal_color,
  input  logic               blink_flag,
  output pix_mode_e          mode_nx,
  output logic [COLOR_W-1:0] color_nx
);
  localparam logic [ATTR_W:0] SLOT_LIMIT = (ATTR_W+1)'(TRANSP_SLOTS);

  logic [NUM_WIN-1:0] win_live;
  logic               any_hit;
  logic               low_slot;
  logic               is_black;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_live[w] = osd_en & win_en[w] & win_hit[w];
  end

  assign any_hit  = |win_live;
  assign low_slot = {1'b0, attr_idx} < SLOT_LIMIT;
  assign is_black = (pal_color == '0) && low_slot;

  always_comb begin
    mode_nx  = PIX_TRANSP;
    color_nx = '0;
    if (any_hit && !(blink_flag && !phase_on)) begin
      if (is_black) begin
        mode_nx = transp_dis ? PIX_BLACK : PIX_TRANSP;
      end else begin
        mode_nx  = PIX_SHOW;
        color_nx = pal_color;
      end
    end
  end
endmodule

// File: rtl/osd_line_len.sv
module osd_line_len #(
  parameter int PPL_W    = 3,
  parameter int LEN_W    = 10,
  parameter int BASE_PIX = 512,
  parameter int STEP_PIX = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PPL_W-1:0] ppl_code,
  output logic [LEN_W-1:0] line_px
);
  always_ff @(posedge clk) begin
    if (rst) line_px <= LEN_W'(BASE_PIX);
    else     line_px <= LEN_W'(BASE_PIX + STEP_PIX * int'(ppl_code));
  end
endmodule

// File: rtl/osd_blink_resolver.sv
module osd_blink_resolver
  import osd_res_pkg::*;
#(
  parameter int COLOR_W      = 9,
  parameter int ATTR_W       = 4,
  parameter int NUM_WIN      = 2,
  parameter int TRANSP_SLOTS = 8,
  parameter int BLINK_W      = 5,
  parameter int MULT_LOG2    = 3,
  parameter int PPL_W        = 3,
  parameter int LEN_W        = 10,
  parameter int BASE_PIX     = 512,
  parameter int STEP_PIX     = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_osd_en,
  input  logic [NUM_WIN-1:0] cfg_win_en,
  input  logic               cfg_transp_dis,
  input  logic [BLINK_W-1:0] cfg_blink_val,
  input  logic [PPL_W-1:0]   cfg_ppl_code,
  input  logic               vsync,
  input  logic [NUM_WIN-1:0] win_hit,
  input  logic [ATTR_W-1:0]  attr_idx,
  input  logic [COLOR_W-1:0] pal_color,
  input  logic               blink_flag,
  output logic [1:0]         pix_mode,
  output logic [COLOR_W-1:0] pix_color,
  output logic               blink_phase,
  output logic [LEN_W-1:0]   line_pixels
);
  pix_mode_e          mode_nx;
  logic [COLOR_W-1:0] color_nx;

  osd_blink_timer #(.BLINK_W(BLINK_W), .MULT_LOG2(MULT_LOG2)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .vsync     (vsync),
    .blink_val (cfg_blink_val),
    .phase_on  (blink_phase)
  );

  osd_pixel_resolve #(
    .COLOR_W(COLOR_W), .ATTR_W(ATTR_W), .NUM_WIN(NUM_WIN), .TRANSP_SLOTS(TRANSP_SLOTS)
  ) u_resolve (
    .osd_en     (cfg_osd_en),
    .win_en     (cfg_win_en),
    .transp_dis (cfg_transp_dis),
    .phase_on   (blink_phase),
    .win_hit    (win_hit),
    .attr_idx   (attr_idx),
    .pal_color  (pal_color),
    .blink_flag (blink_flag),
    .mode_nx    (mode_nx),
    .color_nx   (color_nx)
  );

  osd_line_len #(
    .PPL_W(PPL_W), .LEN_W(LEN_W), .BASE_PIX(BASE_PIX), .STEP_PIX(STEP_PIX)
  ) u_len (
    .clk      (clk),
    .rst      (rst),
    .ppl_code (cfg_ppl_code),
    .line_px  (line_pixels)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_mode  <= PIX_TRANSP;
      pix_color <= '0;
    end else begin
      pix_mode  <= mode_nx;
      pix_color <= color_nx;
    end
  end
endmodule

// File: rtl/osd_resolver_chk.sv
module osd_resolver_chk #(
  parameter int COLOR_W      = 9,
  parameter int ATTR_W       = 4,
  parameter int NUM_WIN      = 2,
  parameter int TRANSP_SLOTS = 8,
  parameter int BLINK_W      = 5,
  parameter int PPL_W        = 3,
  parameter int LEN_W        = 10,
  parameter int BASE_PIX     = 512,
  parameter int STEP_PIX     = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_osd_en,
  input logic [NUM_WIN-1:0] cfg_win_en,
  input logic               cfg_transp_dis,
  input logic [BLINK_W-1:0] cfg_blink_val,
  input logic [PPL_W-1:0]   cfg_ppl_code,
  input logic               vsync,
  input logic [NUM_WIN-1:0] win_hit,
  input logic [ATTR_W-1:0]  attr_idx,
  input logic [COLOR_W-1:0] pal_color,
  input logic               blink_flag,
  input logic [1:0]         pix_mode,
  input logic [COLOR_W-1:0] pix_color,
  input logic               blink_phase,
  input logic [LEN_W-1:0]   line_pixels
);
  logic black_hit;
  assign black_hit = cfg_osd_en && ((win_hit & cfg_win_en) != '0) && (pal_color == '0)
                     && (int'(attr_idx) < TRANSP_SLOTS) && !blink_flag;

  assert_off_transparent_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_osd_en |=> pix_mode == 2'd0);

  assert_low_black_transparent_R4: assert property (@(posedge clk) disable iff (rst)
    (black_hit && !cfg_transp_dis) |=> pix_mode == 2'd0);

  assert_low_black_solid_R5: assert property (@(posedge clk) disable iff (rst)
    (black_hit && cfg_transp_dis) |=> (pix_mode == 2'd2 && pix_color == '0));

  assert_phase_on_vsync_R7: assert property (@(posedge clk) disable iff (rst)
    ((blink_phase != $past(blink_phase)) && ($past(cfg_blink_val) != '0) && !$past(rst))
      |-> ($past(vsync) && !$past(vsync, 2)));

  assert_blink_off_visible_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_blink_val == '0) |=> blink_phase);

  assert_line_len_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> line_pixels == LEN_W'(BASE_PIX + STEP_PIX * int'($past(cfg_ppl_code))));

  assert_color_gated_R11: assert property (@(posedge clk) disable iff (rst)
    (pix_mode != 2'd1) |-> pix_color == '0);

  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (rst)
    pix_mode != 2'd3);
endmodule

bind osd_blink_resolver osd_resolver_chk #(
  .COLOR_W(COLOR_W), .ATTR_W(ATTR_W), .NUM_WIN(NUM_WIN), .TRANSP_SLOTS(TRANSP_SLOTS),
  .BLINK_W(BLINK_W), .PPL_W(PPL_W), .LEN_W(LEN_W), .BASE_PIX(BASE_PIX), .STEP_PIX(STEP_PIX)
) u_chk (
  .clk(clk), .rst(rst), .cfg_osd_en(cfg_osd_en), .cfg_win_en(cfg_win_en),
  .cfg_transp_dis(cfg_transp_dis), .cfg_blink_val(cfg_blink_val),
  .cfg_ppl_code(cfg_ppl_code), .vsync(vsync), .win_hit(win_hit),
  .attr_idx(attr_idx), .pal_color(pal_color), .blink_flag(blink_flag),
  .pix_mode(pix_mode), .pix_color(pix_color), .blink_phase(blink_phase),
  .line_pixels(line_pixels)
);

// File: tb/tb_osd_blink_resolver.sv
module tb_osd_blink_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_LEN    = 1200;
  localparam int NUM_SEG    = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_osd_en = 1'b0;
  logic [1:0] cfg_win_en = 2'b00;
  logic       cfg_transp_dis = 1'b0;
  logic [4:0] cfg_blink_val = 5'd0;
  logic [2:0] cfg_ppl_code = 3'd0;
  logic       vsync = 1'b0;
  logic [1:0] win_hit = 2'b00;
  logic [3:0] attr_idx = 4'd0;
  logic [8:0] pal_color = 9'd0;
  logic       blink_flag = 1'b0;
  logic [1:0] pix_mode;
  logic [8:0] pix_color;
  logic       blink_phase;
  logic [9:0] line_pixels;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  int    m_cnt = 0;
  bit    m_phase = 1;
  bit    m_vsprev = 0;
  int    e_mode = 0;
  int    e_color = 0;
  int    e_line = 512;
  string e_tag = "R1";

  osd_blink_resolver dut (
    .clk(clk), .rst(rst), .cfg_osd_en(cfg_osd_en), .cfg_win_en(cfg_win_en),
    .cfg_transp_dis(cfg_transp_dis), .cfg_blink_val(cfg_blink_val),
    .cfg_ppl_code(cfg_ppl_code), .vsync(vsync), .win_hit(win_hit),
    .attr_idx(attr_idx), .pal_color(pal_color), .blink_flag(blink_flag),
    .pix_mode(pix_mode), .pix_color(pix_color), .blink_phase(blink_phase),
    .line_pixels(line_pixels)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural model: evaluated on each rising edge from the inputs present
  always @(posedge clk) begin
    if (rst) begin
      e_mode = 0; e_color = 0; e_line = 512; e_tag = "R1";
      m_cnt = 0; m_phase = 1; m_vsprev = 0;
    end else begin
      bit hit0, hit1;
      hit0 = cfg_osd_en && cfg_win_en[0] && win_hit[0];
      hit1 = cfg_osd_en && cfg_win_en[1] && win_hit[1];
      e_color = 0;
      if (!cfg_osd_en) begin
        e_mode = 0; e_tag = "R2";
      end else if (!(hit0 || hit1)) begin
        e_mode = 0; e_tag = "R3";
      end else if (blink_flag && !m_phase) begin
        e_mode = 0; e_tag = "R9";
      end else if (pal_color == 0 && attr_idx <= 7) begin
        if (cfg_transp_dis) begin e_mode = 2; e_tag = "R5"; end
        else begin e_mode = 0; e_tag = "R4"; end
      end else begin
        e_mode = 1; e_color = int'(pal_color);
        e_tag = (pal_color == 0) ? "R6" : "R11";
      end
      e_line = 512 + 64 * int'(cfg_ppl_code);
      if (cfg_blink_val == 0) begin
        m_cnt = 0; m_phase = 1;
      end else if (vsync && !m_vsprev) begin
        if (m_cnt + 1 >= 8 * int'(cfg_blink_val)) begin
          m_cnt = 0; m_phase = !m_phase;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      m_vsprev = vsync;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset values
    check(pix_mode == 2'd0, "R1", "pix_mode", int'(pix_mode), 0);
    check(pix_color == 9'd0, "R1", "pix_color", int'(pix_color), 0);
    check(blink_phase == 1'b1, "R1", "blink_phase", int'(blink_phase), 1);
    check(line_pixels == 10'd512, "R1", "line_pixels", int'(line_pixels), 512);
    rst = 1'b0;
    for (int seg = 0; seg < NUM_SEG; seg++) begin
      cfg_osd_en     = (seg != 2);
      cfg_win_en     = (seg == 4) ? 2'b00 : 2'((seg % 3) + 1);
      cfg_transp_dis = seg[0];
      cfg_ppl_code   = 3'(seg);
      case (seg)
        0: cfg_blink_val = 5'd1;
        1: cfg_blink_val = 5'd2;
        2: cfg_blink_val = 5'd0;
        3: cfg_blink_val = 5'd1;
        4: cfg_blink_val = 5'd3;
        5: cfg_blink_val = 5'd31;
        6: cfg_blink_val = 5'd1;
        7: cfg_blink_val = 5'd0;
        8: cfg_blink_val = 5'd2;
        default: cfg_blink_val = 5'd1;
      endcase
      for (int cyc = 0; cyc < SEG_LEN; cyc++) begin
        @(negedge clk);
        check(int'(pix_mode) == e_mode, e_tag, "pix_mode", int'(pix_mode), e_mode);
        check(int'(pix_color) == e_color, e_tag, "pix_color", int'(pix_color), e_color);
        check(blink_phase == m_phase, (cfg_blink_val == 0) ? "R8" : "R7",
              "blink_phase", int'(blink_phase), int'(m_phase));
        check(int'(line_pixels) == e_line, "R10", "line_pixels", int'(line_pixels), e_line);
        vsync      = (cyc % 3 == 0);
        win_hit    = 2'($urandom_range(0, 3));
        attr_idx   = 4'($urandom_range(0, 15));
        pal_color  = ($urandom_range(0, 2) == 0) ? 9'd0 : 9'($urandom_range(0, 511));
        blink_flag = ($urandom_range(0, 2) == 0);
      end
    end
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule